// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass control for a five-stage in-order integer pipeline: fetch, decode, execute, memory and writeback. It looks at the register numbers and a few control flags held in the decode, execute, memory and writeback pipeline registers. From these it chooses where each execute-stage ALU operand comes from and where the memory-stage store data comes from. It also decides when the program counter and the fetch/decode register must hold, when a bubble goes into the decode/execute register, and when wrong-path instructions are killed.

Data produced by an ALU instruction reaches the instruction right behind it with no lost cycle. A load followed at once by a consumer costs one bubble, and the consumer then picks up the loaded value on the writeback bypass. Branches are predicted not taken and resolve in execute. A taken branch kills the two younger instructions and redirects fetch, which costs two cycles. A branch that is not taken costs nothing. The ALU, the register file, the caches and the pipeline registers themselves live outside this block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each execute operand select (`opa_sel`, `opb_sel`) takes 2'b10 when the memory-stage producer writes the operand's register. Otherwise it takes 2'b01 when the writeback-stage producer writes that register. Otherwise it takes 2'b00, the register-file value.
- R2: Register 0 never matches any producer, and a producer whose write flag is low never matches. Bubbles therefore never cause a bypass or a stall.
- R3: A load-use stall arises when a load is in execute and the decode instruction actually reads that load's nonzero destination register. In that same cycle `pc_hold`, `fd_hold` and `de_bubble` are all 1.
- R4: A stall is never asserted in two consecutive cycles. A load-use request in the cycle right after a stall cycle is ignored.
- R5: When the branch in execute resolves taken, `fd_squash`, `de_bubble` and `pc_redirect` are all 1 in that cycle.
- R6: When a taken branch and a load-use request occur together, the squash wins and `pc_hold` and `fd_hold` stay 0.
- R7: `store_data_sel` is 1 when a store is in memory and the writeback-stage producer writes the store's data register, which must be nonzero. Otherwise it is 0.
- R8: With no taken branch and no load-use request, `pc_hold`, `fd_hold`, `fd_squash`, `de_bubble` and `pc_redirect` are all 0, so a not-taken branch loses no cycle.
- R9: The following sequence loses exactly three writeback cycles in total, and neither wrong-path instruction ever reaches writeback:
  - a load;
  - an add that uses the loaded register;
  - a taken branch that uses the add's result;
  - two wrong-path instructions.

  In this sequence the add gets its operand on the writeback bypass, and the branch gets its operand on the memory bypass.
- R10: After reset, the first load-use request is honored at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | Decode first source register |
| id_rs2 | input | 5 | Decode second source register |
| id_use_a | input | 1 | Decode instruction reads its first source |
| id_use_b | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_store_rs | input | 5 | Data register of the store in memory |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| opa_sel | output | 2 | First ALU operand source: 00 register file, 01 writeback, 10 memory |
| opb_sel | output | 2 | Second ALU operand source, same encoding |
| store_data_sel | output | 1 | Store data taken from writeback bypass |
| pc_hold | output | 1 | Hold the program counter |
| fd_hold | output | 1 | Hold the fetch/decode register |
| fd_squash | output | 1 | Turn the fetch/decode register into a bubble |
| de_bubble | output | 1 | Load a bubble into the decode/execute register |
| pc_redirect | output | 1 | Fetch from the branch target next cycle |

## Verification
The assertions check the following on every cycle:
- the operand priority and the register-0 exclusion;
- that a load-use hazard raises all three stall controls;
- that a stall never lasts two cycles;
- that a taken branch forces squash and redirect and overrides a stall;
- the store-data bypass condition.

The total cost of a hazard sequence can only be shown by the bench, which replays an instruction sequence through a pipeline model and counts lost writeback cycles. The same holds for which bypass path feeds each instruction, and for whether wrong-path instructions are ever retired.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int REG_W   = 5;
    parameter int NUM_OPS = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     wen;
    } producer_t;

    function automatic logic writes_reg(reg_idx_t src, producer_t p);
        return p.wen && (p.rd != '0) && (p.rd == src);
    endfunction
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  reg_idx_t  srcs [N],
    input  producer_t near_p,
    input  producer_t far_p,
    output opnd_src_e sel  [N]
);
    for (genvar i = 0; i < N; i++) begin : g_op
        always_comb begin
            if (writes_reg(srcs[i], near_p))
                sel[i] = SRC_MEM;
            else if (writes_reg(srcs[i], far_p))
                sel[i] = SRC_WB;
            else
                sel[i] = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_idx_t  dec_src [NUM_OPS],
    input  logic      dec_use [NUM_OPS],
    input  producer_t ex_prod,
    input  logic      ex_is_load,
    input  logic      ex_taken,
    output logic      hold_pc,
    output logic      hold_fd,
    output logic      kill_fd,
    output logic      kill_de,
    output logic      redirect
);
    logic [NUM_OPS-1:0] dep;
    logic               use_req;
    logic               stall;
    logic               stall_q;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_dep
        assign dep[i] = dec_use[i] && writes_reg(dec_src[i], ex_prod);
    end

    assign use_req  = ex_is_load && (|dep);
    assign stall    = use_req && !ex_taken && !stall_q;
    assign hold_pc  = stall;
    assign hold_fd  = stall;
    assign kill_fd  = ex_taken;
    assign kill_de  = stall || ex_taken;
    assign redirect = ex_taken;

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= stall;
    end
endmodule

// File: rtl/hz_store_bypass.sv
module hz_store_bypass
    import hz_pkg::*;
(
    input  logic      is_store,
    input  reg_idx_t  data_src,
    input  producer_t wb_prod,
    output logic      use_wb
);
    assign use_wb = is_store && writes_reg(data_src, wb_prod);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_load,
    input  logic             ex_br_taken,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr_en,
    input  logic             mem_store,
    input  logic [REG_W-1:0] mem_store_rs,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr_en,
    output logic [1:0]       opa_sel,
    output logic [1:0]       opb_sel,
    output logic             store_data_sel,
    output logic             pc_hold,
    output logic             fd_hold,
    output logic             fd_squash,
    output logic             de_bubble,
    output logic             pc_redirect
);
    producer_t ex_p, mem_p, wb_p;
    reg_idx_t  ex_srcs  [NUM_OPS];
    reg_idx_t  dec_srcs [NUM_OPS];
    logic      dec_uses [NUM_OPS];
    opnd_src_e op_sel   [NUM_OPS];

    assign ex_p  = '{rd: ex_rd,  wen: ex_wr_en};
    assign mem_p = '{rd: mem_rd, wen: mem_wr_en};
    assign wb_p  = '{rd: wb_rd,  wen: wb_wr_en};

    assign ex_srcs[0]  = ex_rs1;
    assign ex_srcs[1]  = ex_rs2;
    assign dec_srcs[0] = id_rs1;
    assign dec_srcs[1] = id_rs2;
    assign dec_uses[0] = id_use_a;
    assign dec_uses[1] = id_use_b;

    hz_fwd_unit #(.N(NUM_OPS)) u_fwd (
        .srcs   (ex_srcs),
        .near_p (mem_p),
        .far_p  (wb_p),
        .sel    (op_sel)
    );

    hz_interlock u_ilk (
        .clk        (clk),
        .rst        (rst),
        .dec_src    (dec_srcs),
        .dec_use    (dec_uses),
        .ex_prod    (ex_p),
        .ex_is_load (ex_load),
        .ex_taken   (ex_br_taken),
        .hold_pc    (pc_hold),
        .hold_fd    (fd_hold),
        .kill_fd    (fd_squash),
        .kill_de    (de_bubble),
        .redirect   (pc_redirect)
    );

    hz_store_bypass u_stb (
        .is_store (mem_store),
        .data_src (mem_store_rs),
        .wb_prod  (wb_p),
        .use_wb   (store_data_sel)
    );

    assign opa_sel = op_sel[0];
    assign opb_sel = op_sel[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker
    import hz_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic             id_use_a,
    input logic             id_use_b,
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_wr_en,
    input logic             ex_load,
    input logic             ex_br_taken,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_wr_en,
    input logic             mem_store,
    input logic [REG_W-1:0] mem_store_rs,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_wr_en,
    input logic [1:0]       opa_sel,
    input logic             store_data_sel,
    input logic             pc_hold,
    input logic             fd_hold,
    input logic             fd_squash,
    input logic             de_bubble,
    input logic             pc_redirect
);
    logic lu_req;
    assign lu_req = ex_load && ex_wr_en && (ex_rd != '0) &&
                    ((id_use_a && id_rs1 == ex_rd) || (id_use_b && id_rs2 == ex_rd));

    p_mem_first_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_rd != '0 && mem_rd == ex_rs1) |-> opa_sel == 2'b10);

    p_wb_second_r1: assert property (@(posedge clk) disable iff (rst)
        (!(mem_wr_en && mem_rd == ex_rs1) && wb_wr_en && wb_rd != '0 && wb_rd == ex_rs1)
        |-> opa_sel == 2'b01);

    p_x0_never_r2: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == '0) |-> opa_sel == 2'b00);

    p_loaduse_r3: assert property (@(posedge clk) disable iff (rst)
        (lu_req && !ex_br_taken && !$past(pc_hold)) |-> (pc_hold && fd_hold && de_bubble));

    p_single_stall_r4: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold);

    p_squash_r5: assert property (@(posedge clk) disable iff (rst)
        ex_br_taken |-> (fd_squash && de_bubble && pc_redirect));

    p_squash_wins_r6: assert property (@(posedge clk) disable iff (rst)
        ex_br_taken |-> (!pc_hold && !fd_hold));

    p_store_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_store && wb_wr_en && wb_rd != '0 && wb_rd == mem_store_rs) |-> store_data_sel);

    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!ex_br_taken && !lu_req) |-> !(pc_hold || fd_hold || fd_squash || de_bubble || pc_redirect));
endmodule

bind pipe_hazard_ctrl hz_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .id_rs1         (id_rs1),
    .id_rs2         (id_rs2),
    .id_use_a       (id_use_a),
    .id_use_b       (id_use_b),
    .ex_rs1         (ex_rs1),
    .ex_rd          (ex_rd),
    .ex_wr_en       (ex_wr_en),
    .ex_load        (ex_load),
    .ex_br_taken    (ex_br_taken),
    .mem_rd         (mem_rd),
    .mem_wr_en      (mem_wr_en),
    .mem_store      (mem_store),
    .mem_store_rs   (mem_store_rs),
    .wb_rd          (wb_rd),
    .wb_wr_en       (wb_wr_en),
    .opa_sel        (opa_sel),
    .store_data_sel (store_data_sel),
    .pc_hold        (pc_hold),
    .fd_hold        (fd_hold),
    .fd_squash      (fd_squash),
    .de_bubble      (de_bubble),
    .pc_redirect    (pc_redirect)
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_store_rs, wb_rd;
    logic id_use_a, id_use_b, ex_wr_en, ex_load, ex_br_taken, mem_wr_en, mem_store, wb_wr_en;
    logic [1:0] opa_sel, opb_sel;
    logic store_data_sel, pc_hold, fd_hold, fd_squash, de_bubble, pc_redirect;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pipe_hazard_ctrl dut_i (.*);

    typedef struct {
        logic v; int tag; logic [4:0] rd, rs1, rs2;
        logic wen, ld, st, br, u1, u2;
    } ins_t;

    ins_t trace [6];
    ins_t s_id, s_ex, s_mem, s_wb, bub;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(logic [4:0] s, logic [4:0] mr, logic mw, logic [4:0] wr, logic ww);
        if (s != 0 && mw && mr == s) return 2;
        if (s != 0 && ww && wr == s) return 1;
        return 0;
    endfunction

    function automatic logic exp_req();
        return ex_load && ex_wr_en && ex_rd != 0 &&
               ((id_use_a && id_rs1 == ex_rd) || (id_use_b && id_rs2 == ex_rd));
    endfunction

    task automatic clear_in();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_store_rs, wb_rd} = '0;
        {id_use_a, id_use_b, ex_wr_en, ex_load, ex_br_taken, mem_wr_en, mem_store, wb_wr_en} = '0;
    endtask

    function automatic ins_t mk(int tag, int rd, int a, int b, logic wen, logic ld, logic br);
        ins_t i;
        i.v = 1; i.tag = tag; i.rd = 5'(rd); i.rs1 = 5'(a); i.rs2 = 5'(b);
        i.wen = wen; i.ld = ld; i.st = 0; i.br = br; i.u1 = 1; i.u2 = !ld;
        return i;
    endfunction

    task automatic drive_stages();
        id_rs1 = s_id.rs1; id_rs2 = s_id.rs2;
        id_use_a = s_id.v && s_id.u1; id_use_b = s_id.v && s_id.u2;
        ex_rs1 = s_ex.rs1; ex_rs2 = s_ex.rs2; ex_rd = s_ex.rd;
        ex_wr_en = s_ex.v && s_ex.wen; ex_load = s_ex.v && s_ex.ld;
        ex_br_taken = s_ex.v && s_ex.br;
        mem_rd = s_mem.rd; mem_wr_en = s_mem.v && s_mem.wen;
        mem_store = s_mem.v && s_mem.st; mem_store_rs = s_mem.rs2;
        wb_rd = s_wb.rd; wb_wr_en = s_wb.v && s_wb.wen;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit prev_stall;
        int wbtag [16];
        int pc, holds, squashes, ld_at, tgt_at, lost;
        ins_t nid;
        void'($urandom(32'd7));
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #2;
        // reset state
        chk("R8 reset opa", int'(opa_sel), 0);
        chk("R8 reset hold", int'(pc_hold | fd_hold | de_bubble | fd_squash | pc_redirect), 0);

        // R10: load-use right after reset is honored at once
        @(posedge clk); #1;
        ex_load = 1; ex_wr_en = 1; ex_rd = 5'd3; id_rs1 = 5'd3; id_use_a = 1;
        #2 chk("R10 first stall", int'({pc_hold, fd_hold, de_bubble}), 7);
        // R4: request persists next cycle, must be ignored
        @(posedge clk); #3;
        chk("R4 no second stall", int'({pc_hold, fd_hold, de_bubble}), 0);
        // R3 then on third cycle stall again
        @(posedge clk); #3;
        chk("R3 stall again", int'(pc_hold), 1);
        // R6: taken branch together with request
        @(posedge clk); #1 ex_br_taken = 1;
        #2 chk("R6 squash wins hold", int'({pc_hold, fd_hold}), 0);
        chk("R5 squash", int'({fd_squash, de_bubble, pc_redirect}), 7);
        // R2: x0 never matches
        @(posedge clk); #1 clear_in();
        ex_load = 1; ex_wr_en = 1; ex_rd = 0; id_rs1 = 0; id_use_a = 1;
        ex_rs1 = 0; mem_rd = 0; mem_wr_en = 1; wb_rd = 0; wb_wr_en = 1;
        #2 chk("R2 x0 no stall", int'(pc_hold), 0);
        chk("R2 x0 no bypass", int'(opa_sel), 0);
        // R2: unused source does not stall
        @(posedge clk); #1 clear_in();
        ex_load = 1; ex_wr_en = 1; ex_rd = 5'd4; id_rs2 = 5'd4; id_use_b = 0;
        #2 chk("R2 unused src", int'(pc_hold), 0);
        // R7 store bypass
        @(posedge clk); #1 clear_in();
        mem_store = 1; mem_store_rs = 5'd6; wb_rd = 5'd6; wb_wr_en = 1;
        #2 chk("R7 store bypass", int'(store_data_sel), 1);
        @(posedge clk); #1 wb_wr_en = 0;
        #2 chk("R7 no write no bypass", int'(store_data_sel), 0);

        // random phase
        @(posedge clk); #1 clear_in();
        prev_stall = 0;
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #1;
            id_rs1 = 5'($urandom % 4); id_rs2 = 5'($urandom % 4);
            id_use_a = 1'($urandom % 2); id_use_b = 1'($urandom % 2);
            ex_rs1 = 5'($urandom % 4); ex_rs2 = 5'($urandom % 4); ex_rd = 5'($urandom % 4);
            ex_wr_en = 1'($urandom % 2); ex_load = 1'($urandom % 2);
            ex_br_taken = ($urandom % 6) == 0;
            mem_rd = 5'($urandom % 4); mem_wr_en = 1'($urandom % 2);
            mem_store = 1'($urandom % 2); mem_store_rs = 5'($urandom % 4);
            wb_rd = 5'($urandom % 4); wb_wr_en = 1'($urandom % 2);
            #2;
            begin
                bit st;
                st = exp_req() && !ex_br_taken && !prev_stall;
                chk("R1 opa", int'(opa_sel), exp_sel(ex_rs1, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
                chk("R1 opb", int'(opb_sel), exp_sel(ex_rs2, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
                chk("R3 R4 R6 hold", int'({pc_hold, fd_hold}), st ? 3 : 0);
                chk("R5 R8 flush", int'({fd_squash, de_bubble, pc_redirect}),
                    ex_br_taken ? 7 : (st ? 2 : 0));
                chk("R7 store", int'(store_data_sel),
                    int'(mem_store && wb_wr_en && wb_rd != 0 && wb_rd == mem_store_rs));
                prev_stall = st;
            end
        end

        // R9 trace replay
        @(posedge clk); #1 clear_in();
        @(posedge clk);
        bub = '{v:0, tag:-1, rd:0, rs1:0, rs2:0, wen:0, ld:0, st:0, br:0, u1:0, u2:0};
        trace[0] = mk(0, 1, 10, 0, 1, 1, 0);
        trace[1] = mk(1, 2, 1, 3, 1, 0, 0);
        trace[2] = mk(2, 0, 2, 4, 0, 0, 1);
        trace[3] = mk(3, 5, 6, 7, 1, 0, 0);
        trace[4] = mk(4, 8, 9, 11, 1, 0, 0);
        trace[5] = mk(5, 12, 13, 14, 1, 0, 0);
        s_id = bub; s_ex = bub; s_mem = bub; s_wb = bub;
        pc = 0; holds = 0; squashes = 0;
        for (int c = 0; c < 16; c++) begin
            #1 drive_stages();
            #2;
            wbtag[c] = s_wb.v ? s_wb.tag : -1;
            if (s_ex.v && s_ex.tag == 1) chk("R9 add via wb bypass", int'(opa_sel), 1);
            if (s_ex.v && s_ex.tag == 2) chk("R9 branch via mem bypass", int'(opa_sel), 2);
            if (pc_hold) holds++;
            if (fd_squash) squashes++;
            nid = fd_squash ? bub : (fd_hold ? s_id : ((pc < 6) ? trace[pc] : bub));
            s_wb = s_mem; s_mem = s_ex;
            s_ex = de_bubble ? bub : s_id;
            s_id = nid;
            if (pc_redirect) pc = 5;
            else if (!pc_hold) pc++;
            @(posedge clk);
        end
        ld_at = -1; tgt_at = -1; lost = 0;
        for (int c = 0; c < 16; c++) begin
            if (wbtag[c] == 0) ld_at = c;
            if (wbtag[c] == 5) tgt_at = c;
            chk("R9 wrong path retired", int'(wbtag[c] == 3 || wbtag[c] == 4), 0);
        end
        for (int c = 0; c < 16; c++)
            if (ld_at >= 0 && c > ld_at && c < tgt_at && wbtag[c] == -1) lost++;
        chk("R9 target retired", int'(tgt_at > ld_at && ld_at >= 0), 1);
        chk("R9 lost cycles", lost, 3);
        chk("R9 one stall cycle", holds, 1);
        chk("R9 one squash cycle", squashes, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule